// File: doc/BRIEF.md
# 64-Source Interrupt Controller

This block collects 64 interrupt request lines and presents them to a processor through a small register bus. The bus has byte enables and one-cycle read latency. Each source owns an 8-bit control byte. The byte sets whether the source is enabled, how its input is sensed (level or an edge), and which processor input it feeds. Edge-sensed sources are captured in status bits. Software clears those bits by writing ones.

Enabled, pending sources are gathered onto two registered outputs, a normal interrupt line and a fast interrupt line. For each line, a priority register names the winning source. The search is either fixed (the lowest number wins) or rotating (the search starts just after the last source reported). When nothing is pending, the priority register returns 63. Software therefore reads status bit 63 to tell a real source 63 from an idle reading.

Top module: `irq_ctrl64`

## Requirements
- R1: After a synchronous reset, every control byte is 0, every status bit is 0, `irq_out` and `fiq_out` are low, both rotation bits are 0, and both priority registers read 0x3F.
- R2: The control byte of source n sits at byte address 0x40+n. Bus word 0x40+4k holds sources 4k..4k+3, with source 4k+b in byte lane b. The byte is written per lane under `bus_be` and reads back unchanged. Bit 3 is the enable, and a source whose bit 3 is 0 never drives either output.
- R3: Control bits 6:5 choose the sensing: 00 is active-high level, 01 latches a rising edge, 10 latches a falling edge, and 11 latches either edge.
- R4: Control bits 2:0 choose the destination: 0 is `irq_out`, 1 is `fiq_out`, and codes 2 to 7 reach neither output.
- R5: Status for sources 0-31 reads at 0x80 and for 32-63 at 0x84 (bit n%32). For an edge source, writing 1 to its bit with its byte lane enabled clears the bit, and writing 0 or a disabled lane leaves it unchanged. A level source shows its synchronized input and ignores clear writes.
- R6: Each input passes through two synchronizer flops and then into a status flop. `irq_out`/`fiq_out` are registered ORs of the enabled status bits routed to them. An input change therefore reaches the output on the fourth rising clock edge.
- R7: Reading 0x20 (IRQ) or 0x24 (FIQ) returns in bits 5:0 the winning enabled, pending source routed to that output, or 63 when there is none. Bit 6 reads back the rotation setting, and all other bits are 0. With rotation off, the lowest source number wins.
- R8: Writing bit 6 of 0x20/0x24 (lane 0) turns rotation on for that output. With rotation on, the search starts one past that output's last reported source and wraps from 63 to 0. Each output keeps its own pointer. The pointer is 63 after reset and changes only when that priority register is read while a source is pending, in either mode.
- R9: Read data appears on `bus_rdata` in the cycle after `bus_rd`, and it is 0 in every cycle that does not follow a read. Addresses outside the map read 0 and ignore writes. Addresses are word-aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Word-aligned byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_be | input | 4 | Byte lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| src_in | input | 64 | Asynchronous interrupt request lines |
| irq_out | output | 1 | Normal interrupt output |
| fiq_out | output | 1 | Fast interrupt output |

## Verification
The hardest state to reach is the rotating pointer sitting at a chosen source while several sources are pending together. The pointer then has to survive a read that finds nothing. Because the pointer is visible only through the priority register, the stimulus gets there in steps. It holds three level sources high and reads once in fixed mode to seat the pointer. It then switches rotation on and reads repeatedly, watching the answer walk and wrap. Next it drops all lines, reads the idle value of 63, and raises the lines again. The following read must resume after the last reported source. A behavioural model in the bench checks the outputs and read data on every cycle of this sequence.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int REG_AW = 8;
  localparam logic [REG_AW-1:0] A_PRIO_IRQ  = 8'h20;
  localparam logic [REG_AW-1:0] A_CTL_BASE  = 8'h40;
  localparam logic [REG_AW-1:0] A_STAT_BASE = 8'h80;
  localparam int CB_EN   = 3;
  localparam int CB_RISE = 5;
  localparam int CB_FALL = 6;
  localparam int PR_ROT  = 6;

  typedef enum logic [1:0] {
    TRIG_LEVEL = 2'b00,
    TRIG_RISE  = 2'b01,
    TRIG_FALL  = 2'b10,
    TRIG_BOTH  = 2'b11
  } trig_e;

  typedef enum logic [2:0] {
    DST_IRQ = 3'd0,
    DST_FIQ = 3'd1
  } dst_e;
endpackage

// File: rtl/irq_src_cell.sv
// One source: input synchronizer, edge detector and status flop.
module irq_src_cell
  import irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  src_i,
  input  trig_e trig_i,
  input  logic  clr_i,
  output logic  stat_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic prev_q;
  logic live, rise, fall;

  assign live = sync_q[SYNC_STAGES-1];
  assign rise = live & ~prev_q;
  assign fall = ~live & prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      stat_o <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], src_i};
      prev_q <= live;
      unique case (trig_i)
        TRIG_LEVEL: stat_o <= live;
        TRIG_RISE:  stat_o <= (stat_o & ~clr_i) | rise;
        TRIG_FALL:  stat_o <= (stat_o & ~clr_i) | fall;
        TRIG_BOTH:  stat_o <= (stat_o & ~clr_i) | rise | fall;
      endcase
    end
  end
endmodule

// File: rtl/irq_pick.sv
// Circular first-set search starting at start_i; N must be a power of two.
module irq_pick #(
  parameter int N  = 64,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  pend_i,
  input  logic [IW-1:0] start_i,
  output logic          hit_o,
  output logic [IW-1:0] idx_o
);
  logic [N-1:0]  rot;
  logic [IW-1:0] off;

  always_comb begin
    rot = N'({pend_i, pend_i} >> start_i);
    off = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (rot[k]) off = IW'(k);
    end
    hit_o = |pend_i;
    idx_o = hit_o ? start_i + off : '1;
  end
endmodule

// File: rtl/irq_ctrl64.sv
module irq_ctrl64
  import irq_pkg::*;
#(
  parameter int N_SRC       = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [N_SRC-1:0]  src_in,
  output logic              irq_out,
  output logic              fiq_out
);
  localparam int IW       = $clog2(N_SRC);
  localparam int N_STAT_W = N_SRC / 32;
  localparam int N_OUT    = 2;

  logic [N_SRC-1:0][7:0]        ctl_q;
  logic [N_SRC-1:0]             stat_v, clr_v;
  logic [N_OUT-1:0][N_SRC-1:0]  pend_v;
  logic [N_OUT-1:0]             rot_q, hit_v;
  logic [N_OUT-1:0][IW-1:0]     last_q, start_v, win_v;
  logic [N_SRC-1:0]             pend_irq_v;
  logic [IW-1:0]                ptr_irq;
  logic                         ctl_hit;
  logic [31:0]                  rd_mux;

  // Control bytes occupy an N_SRC-aligned window.
  assign ctl_hit = (bus_addr[REG_AW-1:IW] == A_CTL_BASE[REG_AW-1:IW]);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
    end else if (bus_wr && ctl_hit) begin
      for (int i = 0; i < N_SRC; i++) begin
        if (bus_addr[IW-1:2] == (IW-2)'(i / 4) && bus_be[i % 4])
          ctl_q[i] <= bus_wdata[8*(i % 4) +: 8];
      end
    end
  end

  // Write-one-to-clear strobes per source.
  always_comb begin
    clr_v = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (bus_wr && bus_addr == A_STAT_BASE + REG_AW'(4 * (i / 32)) &&
          bus_be[(i % 32) / 8])
        clr_v[i] = bus_wdata[i % 32];
    end
  end

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    irq_src_cell #(.SYNC_STAGES(SYNC_STAGES)) u_cell (
      .clk    (clk),
      .rst    (rst),
      .src_i  (src_in[g]),
      .trig_i (trig_e'(ctl_q[g][CB_FALL:CB_RISE])),
      .clr_i  (clr_v[g]),
      .stat_o (stat_v[g])
    );
  end

  always_comb begin
    for (int i = 0; i < N_SRC; i++) begin
      pend_v[0][i] = stat_v[i] & ctl_q[i][CB_EN] & (ctl_q[i][2:0] == DST_IRQ);
      pend_v[1][i] = stat_v[i] & ctl_q[i][CB_EN] & (ctl_q[i][2:0] == DST_FIQ);
    end
  end

  assign pend_irq_v = pend_v[0];
  assign ptr_irq    = last_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_out <= 1'b0;
      fiq_out <= 1'b0;
    end else begin
      irq_out <= |pend_v[0];
      fiq_out <= |pend_v[1];
    end
  end

  // Priority search per output.
  always_comb begin
    for (int o = 0; o < N_OUT; o++)
      start_v[o] = rot_q[o] ? last_q[o] + 1'b1 : '0;
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    irq_pick #(.N(N_SRC), .IW(IW)) u_pick (
      .pend_i  (pend_v[o]),
      .start_i (start_v[o]),
      .hit_o   (hit_v[o]),
      .idx_o   (win_v[o])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rot_q  <= '0;
      last_q <= '1;
    end else begin
      for (int o = 0; o < N_OUT; o++) begin
        if (bus_wr && bus_be[0] && bus_addr == A_PRIO_IRQ + REG_AW'(4 * o))
          rot_q[o] <= bus_wdata[PR_ROT];
        if (bus_rd && hit_v[o] && bus_addr == A_PRIO_IRQ + REG_AW'(4 * o))
          last_q[o] <= win_v[o];
      end
    end
  end

  // Read path.
  always_comb begin
    rd_mux = '0;
    if (ctl_hit) begin
      for (int b = 0; b < 4; b++)
        rd_mux[8*b +: 8] = ctl_q[{bus_addr[IW-1:2], 2'(b)}];
    end
    for (int w = 0; w < N_STAT_W; w++) begin
      if (bus_addr == A_STAT_BASE + REG_AW'(4 * w))
        rd_mux = stat_v[32*w +: 32];
    end
    for (int o = 0; o < N_OUT; o++) begin
      if (bus_addr == A_PRIO_IRQ + REG_AW'(4 * o)) begin
        rd_mux[IW-1:0] = win_v[o];
        rd_mux[PR_ROT] = rot_q[o];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
    else             bus_rdata <= '0;
  end
endmodule

// File: rtl/irq_ctrl64_chk.sv
module irq_ctrl64_chk
  import irq_pkg::*;
#(
  parameter int N_SRC = 64,
  parameter int IW    = $clog2(N_SRC)
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_rd,
  input logic [REG_AW-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic              irq_out,
  input logic              fiq_out,
  input logic [N_SRC-1:0]  pend_irq_v,
  input logic [IW-1:0]     ptr_irq
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq_out && !fiq_out && bus_rdata == '0));

  // R6
  irq_follows_pend_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq_out == $past(|pend_irq_v)));

  // R7
  idle_reads_top_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == A_PRIO_IRQ && pend_irq_v == '0) |=> (bus_rdata[IW-1:0] == '1));

  // R8
  ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && bus_addr == A_PRIO_IRQ) |=> $stable(ptr_irq));

  // R9
  rdata_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0));
endmodule

bind irq_ctrl64 irq_ctrl64_chk #(.N_SRC(N_SRC)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_rd     (bus_rd),
  .bus_addr   (bus_addr),
  .bus_rdata  (bus_rdata),
  .irq_out    (irq_out),
  .fiq_out    (fiq_out),
  .pend_irq_v (pend_irq_v),
  .ptr_irq    (ptr_irq)
);

// File: tb/irq_ctrl64_tb_top.sv
module irq_ctrl64_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] src_in = '0;
  logic        irq_out, fiq_out;

  always #10 clk = ~clk;

  irq_ctrl64 dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_in(src_in), .irq_out(irq_out), .fiq_out(fiq_out)
  );

  int n_chk = 0, n_fail = 0;
  bit cmp_on = 0, done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit [63:0] m_s1, m_s2, m_pv, m_st;
  bit [7:0]  m_ctl [64];
  bit        m_rot [2];
  int        m_last [2];
  bit        m_irq, m_fiq;
  bit [31:0] m_rd;
  string     m_tag = "R9";

  function automatic bit [63:0] pend_of(input int dst);
    bit [63:0] p = '0;
    for (int i = 0; i < 64; i++)
      if (m_st[i] && m_ctl[i][3] && m_ctl[i][2:0] == dst[2:0]) p[i] = 1'b1;
    return p;
  endfunction

  function automatic int search(input bit [63:0] p, input int start);
    for (int k = 0; k < 64; k++)
      if (p[(start + k) % 64]) return (start + k) % 64;
    return -1;
  endfunction

  always @(posedge clk) begin : model
    bit [63:0] p0, p1, nst, clr;
    bit [31:0] rd;
    bit [1:0]  tr;
    bit        rise, fall;
    int        a, o, wn, st;
    string     tag;
    if (rst) begin
      m_s1 = '0; m_s2 = '0; m_pv = '0; m_st = '0;
      for (int i = 0; i < 64; i++) m_ctl[i] = '0;
      for (int k = 0; k < 2; k++) begin m_rot[k] = 0; m_last[k] = 63; end
      m_irq = 0; m_fiq = 0; m_rd = '0; m_tag = "R1";
    end else begin
      p0 = pend_of(0); p1 = pend_of(1);
      a = int'(bus_addr);
      rd = '0; tag = "R9";
      if (bus_rd) begin
        if (a >= 'h40 && a < 'h80) begin
          for (int b = 0; b < 4; b++) rd[8*b +: 8] = m_ctl[(a & 'h3C) + b];
          tag = "R2";
        end else if (a == 'h80 || a == 'h84) begin
          rd = (a == 'h80) ? m_st[31:0] : m_st[63:32];
          tag = "R5";
        end else if (a == 'h20 || a == 'h24) begin
          o = (a == 'h24) ? 1 : 0;
          st = m_rot[o] ? (m_last[o] + 1) % 64 : 0;
          wn = search(o == 1 ? p1 : p0, st);
          rd[6] = m_rot[o];
          rd[5:0] = (wn < 0) ? 6'd63 : 6'(wn);
          if (wn >= 0) m_last[o] = wn;
          tag = m_rot[o] ? "R8" : "R7";
        end
      end
      clr = '0;
      if (bus_wr && (a == 'h80 || a == 'h84))
        for (int j = 0; j < 32; j++)
          if (bus_be[j/8] && bus_wdata[j]) clr[(a == 'h84 ? 32 : 0) + j] = 1'b1;
      for (int i = 0; i < 64; i++) begin
        tr = m_ctl[i][6:5];
        rise = m_s2[i] && !m_pv[i];
        fall = !m_s2[i] && m_pv[i];
        if (tr == 2'b00) nst[i] = m_s2[i];
        else nst[i] = (m_st[i] && !clr[i]) || (tr[0] && rise) || (tr[1] && fall);
      end
      if (bus_wr && a >= 'h40 && a < 'h80)
        for (int b = 0; b < 4; b++)
          if (bus_be[b]) m_ctl[(a & 'h3C) + b] = bus_wdata[8*b +: 8];
      if (bus_wr && bus_be[0] && (a == 'h20 || a == 'h24))
        m_rot[a == 'h24 ? 1 : 0] = bus_wdata[6];
      m_pv = m_s2; m_s2 = m_s1; m_s1 = src_in;
      m_st = nst;
      m_irq = |p0; m_fiq = |p1;
      m_rd = rd; m_tag = tag;
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      chk(irq_out === m_irq, "R6 irq_out", 32'(irq_out), 32'(m_irq));
      chk(fiq_out === m_fiq, "R6 fiq_out", 32'(fiq_out), 32'(m_fiq));
      chk(bus_rdata === m_rd, m_tag, bus_rdata, m_rd);
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_be = be; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_expect(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    chk(bus_rdata === exp, tag, bus_rdata, exp);
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    cmp_on = 1'b1;
    // R1 reset state
    chk(irq_out === 1'b0 && fiq_out === 1'b0, "R1 outputs", 32'({irq_out, fiq_out}), 32'h0);
    rd_expect(8'h20, 32'h3F, "R1 irq prio");
    rd_expect(8'h24, 32'h3F, "R1 fiq prio");
    rd_expect(8'h84, 32'h0, "R1 status");
    rd_expect(8'h44, 32'h0, "R1 ctl");
    // R2 / R6 level source 5 to IRQ, source 9 high but disabled
    wr(8'h44, 4'b0010, 32'h0000_0800);
    rd_expect(8'h44, 32'h0000_0800, "R2 ctl readback");
    src_in[5] = 1'b1; src_in[9] = 1'b1;
    settle();
    chk(irq_out === 1'b1, "R6 level irq", 32'(irq_out), 32'h1);
    rd_expect(8'h20, 32'h05, "R7 fixed winner");
    rd_expect(8'h80, 32'h0000_0220, "R5 level status");
    wr(8'h80, 4'hF, 32'h0000_0220);
    rd_expect(8'h80, 32'h0000_0220, "R5 level ignores clear");
    wr(8'h44, 4'b0010, 32'h0);
    settle();
    chk(irq_out === 1'b0, "R2 disabled source silent", 32'(irq_out), 32'h0);
    // R3 rising edge on source 40 to FIQ
    wr(8'h68, 4'b0001, 32'h29);
    src_in[40] = 1'b1; repeat (2) @(negedge clk); src_in[40] = 1'b0;
    settle();
    chk(fiq_out === 1'b1, "R3 rise latched fiq", 32'(fiq_out), 32'h1);
    rd_expect(8'h84, 32'h0000_0100, "R3 rise status");
    rd_expect(8'h24, 32'h28, "R7 fiq winner");
    wr(8'h84, 4'hF, 32'h0);
    rd_expect(8'h84, 32'h0000_0100, "R5 write zero keeps");
    wr(8'h84, 4'b0001, 32'h0000_0100);
    rd_expect(8'h84, 32'h0000_0100, "R5 lane off keeps");
    wr(8'h84, 4'b0010, 32'h0000_0100);
    rd_expect(8'h84, 32'h0, "R5 clear");
    settle();
    chk(fiq_out === 1'b0, "R5 fiq drops after clear", 32'(fiq_out), 32'h0);
    // R3 falling on 41 and both edges on 42
    wr(8'h68, 4'b0110, 32'h0069_4900);
    src_in[41] = 1'b1; src_in[42] = 1'b1;
    settle();
    rd_expect(8'h84, 32'h0000_0400, "R3 rise ignored by falling, both-edge sets");
    wr(8'h84, 4'b0010, 32'h0000_0400);
    src_in[41] = 1'b0; src_in[42] = 1'b0;
    settle();
    rd_expect(8'h84, 32'h0000_0600, "R3 falling and both-edge latch");
    wr(8'h84, 4'b0010, 32'h0000_0600);
    settle();
    // R4 destination 3 reaches neither output
    wr(8'h4C, 4'b0001, 32'h0B);
    src_in[12] = 1'b1;
    settle();
    chk(irq_out === 1'b0 && fiq_out === 1'b0, "R4 aux dest", 32'({irq_out, fiq_out}), 32'h0);
    rd_expect(8'h20, 32'h3F, "R4 irq idle");
    rd_expect(8'h24, 32'h3F, "R4 fiq idle");
    // R8 rotation with sources 5, 6, 20
    wr(8'h44, 4'b0110, 32'h0008_0800);
    wr(8'h54, 4'b0001, 32'h08);
    src_in[6] = 1'b1; src_in[20] = 1'b1;
    settle();
    rd_expect(8'h20, 32'h05, "R7 fixed lowest");
    wr(8'h20, 4'b0001, 32'h40);
    rd_expect(8'h20, 32'h46, "R8 rotate step 1");
    rd_expect(8'h20, 32'h54, "R8 rotate step 2");
    rd_expect(8'h20, 32'h45, "R8 rotate wrap");
    rd_expect(8'h20, 32'h46, "R8 rotate step 4");
    src_in[5] = 1'b0; src_in[6] = 1'b0; src_in[20] = 1'b0;
    settle();
    rd_expect(8'h20, 32'h7F, "R8 idle read");
    src_in[5] = 1'b1; src_in[6] = 1'b1; src_in[20] = 1'b1;
    settle();
    rd_expect(8'h20, 32'h54, "R8 pointer held over idle read");
    wr(8'h20, 4'b0001, 32'h0);
    rd_expect(8'h20, 32'h05, "R7 back to fixed");
    // R9 unmapped
    rd_expect(8'h10, 32'h0, "R9 unmapped read");
    wr(8'h90, 4'hF, 32'hFFFF_FFFF);
    rd_expect(8'h90, 32'h0, "R9 unmapped write");
    rd_expect(8'h28, 32'h0, "R9 unmapped gap");
    settle();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule